// File: doc/BRIEF.md
# Cache Way Shrink Controller

This block decides how many ways of a set-associative last-level cache stay powered. In its full configuration all 16 ways are awake. When a stream of activity samples has stayed low for long enough, it walks through ways 2 to 15 in turn. For each way it asks an external flush engine to write that way back, and it puts the way to sleep only once the engine reports completion. Only the two lowest ways remain awake, which lets the supply be lowered to a smaller minimum voltage, roughly 30 mV lower.

When the samples stay high for long enough while the cache is shrunk, every way is woken at once. A burst of high activity during a shrink sequence cancels the sequence. The way being flushed finishes, no further way is flushed, and all ways come back. Separate low and high thresholds, plus a required run of consecutive qualifying samples, keep the cache from bouncing between the two sizes. A status code and a voltage-lowering permit tell the surrounding power logic where the cache stands.

Top module: `way_shrink_ctrl`

## Requirements
- R1: After reset no way sleeps, `flush_req` is zero, `active_ways` is 16, `size_status` is 2'b00 (full) and `vmin_permit` is low.
- R2: In the full configuration, a shrink starts on the edge of the MIN_DWELL-th consecutive valid sample strictly below `lo_thresh` (MIN_DWELL defaults to 4). Cycles with `act_valid` low neither count nor reset the run.
- R3: During a shrink, ways KEEP_WAYS..15 are flushed in ascending order, one at a time. `flush_req` is one-hot with bit w set for way w, and it stays on the same way until `flush_done` is seen. No request is ever raised for a sleeping way.
- R4: The sleep bit of way w (bit w of `way_sleep`, 1 = asleep) rises on the edge where `flush_done` completes way w's flush and at no other time. Ways 0 and 1 never sleep.
- R5: After the last way's flush completes, `size_status` is 2'b01 (shrunk), `active_ways` is 2 and `vmin_permit` is high.
- R6: In the shrunk configuration, MIN_DWELL consecutive valid samples strictly above `hi_thresh` clear every sleep bit on that edge. `size_status` then shows 2'b10 for one cycle, followed by 2'b00.
- R7: If a valid sample above `hi_thresh` arrives during a shrink sequence, the next `flush_done` does not put the current way to sleep. Instead it clears every sleep bit, and no further flush is requested.
- R8: `size_status` is 2'b10 (moving) while a shrink sequence or a wake cycle is in progress. `vmin_permit` is high only when `size_status` is 2'b01.
- R9: A valid sample that does not qualify resets the consecutive run: in the full configuration, a sample at or above `lo_thresh`; in the shrunk configuration, a sample at or below `hi_thresh`. A `flush_done` with no pending request has no effect.
- R10: `active_ways` always equals 16 minus the number of sleeping ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_valid | input | 1 | Activity sample strobe |
| act_sample | input | ACT_W | Activity measure for this sample |
| lo_thresh | input | ACT_W | Samples below this count toward shrinking |
| hi_thresh | input | ACT_W | Samples above this count toward expanding |
| flush_done | input | 1 | Flush engine finished the requested way |
| flush_req | output | NUM_WAYS | One-hot flush request per way |
| way_sleep | output | NUM_WAYS | Per-way sleep enable |
| active_ways | output | $clog2(NUM_WAYS+1) | Number of awake ways |
| size_status | output | 2 | 00 full, 01 shrunk, 10 moving |
| vmin_permit | output | 1 | Lower minimum voltage allowed |

## Verification
The assertions check properties that must hold on every cycle. The flush request is never more than one-hot, and it never targets a sleeping way. A sleep bit rises only on the edge after that way's request met `flush_done`. The two kept ways never sleep, and the permit appears only in the shrunk state with exactly two ways awake. The bench scenarios cover the timing-dependent behaviour. These include the exact sample count that triggers a transition, the reset of that count by an in-between sample, the flush order, and the cancellation of a shrink by a high sample. The bench also covers the one-cycle moving state on wake-up, and long random runs compared against an independent cycle model.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

  typedef enum logic [1:0] {
    SEQ_FULL   = 2'd0,
    SEQ_FLUSH  = 2'd1,
    SEQ_SHRUNK = 2'd2,
    SEQ_WAKE   = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    SIZE_FULL   = 2'b00,
    SIZE_SHRUNK = 2'b01,
    SIZE_MOVING = 2'b10
  } size_code_e;

  function automatic size_code_e size_of(seq_state_e s);
    case (s)
      SEQ_FULL:   return SIZE_FULL;
      SEQ_SHRUNK: return SIZE_SHRUNK;
      default:    return SIZE_MOVING;
    endcase
  endfunction

endpackage

// File: rtl/wsc_dwell_filter.sv
module wsc_dwell_filter #(
  parameter int ACT_W     = 12,
  parameter int MIN_DWELL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             look_high,
  input  logic             act_valid,
  input  logic [ACT_W-1:0] act_sample,
  input  logic [ACT_W-1:0] lo_thresh,
  input  logic [ACT_W-1:0] hi_thresh,
  output logic             dwell_hit,
  output logic             high_now
);

  localparam int CNT_W = $clog2(MIN_DWELL + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MIN_DWELL - 1);

  function automatic logic is_below(logic [ACT_W-1:0] s, logic [ACT_W-1:0] t);
    return s < t;
  endfunction

  function automatic logic is_above(logic [ACT_W-1:0] s, logic [ACT_W-1:0] t);
    return s > t;
  endfunction

  logic [CNT_W-1:0] run_cnt;
  logic             qualifies;

  assign qualifies = look_high ? is_above(act_sample, hi_thresh)
                               : is_below(act_sample, lo_thresh);
  assign high_now  = act_valid && is_above(act_sample, hi_thresh);
  assign dwell_hit = !clr && act_valid && qualifies && (run_cnt == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (clr || dwell_hit) begin
      run_cnt <= '0;
    end else if (act_valid) begin
      run_cnt <= qualifies ? run_cnt + 1'b1 : '0;
    end
  end

  // R2
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt < CNT_W'(MIN_DWELL));

  // R9
  run_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !qualifies) |=> (run_cnt == '0));

endmodule

// File: rtl/wsc_way_sequencer.sv
module wsc_way_sequencer
  import wsc_pkg::*;
#(
  parameter int NUM_WAYS  = 16,
  parameter int KEEP_WAYS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        dwell_hit,
  input  logic                        high_now,
  input  logic                        flush_done,
  output logic [NUM_WAYS-1:0]         flush_req,
  output logic                        sleep_set,
  output logic [$clog2(NUM_WAYS)-1:0] sleep_idx,
  output logic                        wake_all,
  output logic                        filt_clr,
  output logic                        look_high,
  output seq_state_e                  state
);

  localparam int IDX_W = $clog2(NUM_WAYS);
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(KEEP_WAYS);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_WAYS - 1);

  logic [IDX_W-1:0] way_idx;
  logic             abort_q;
  logic             abort_now;
  logic             in_flush;

  assign in_flush  = (state == SEQ_FLUSH);
  assign abort_now = abort_q || high_now;
  assign sleep_set = in_flush && flush_done && !abort_now;
  assign sleep_idx = way_idx;
  assign wake_all  = (in_flush && flush_done && abort_now) ||
                     ((state == SEQ_SHRUNK) && dwell_hit);
  assign filt_clr  = !((state == SEQ_FULL) || (state == SEQ_SHRUNK));
  assign look_high = (state == SEQ_SHRUNK);

  for (genvar i = 0; i < NUM_WAYS; i++) begin : g_req
    assign flush_req[i] = in_flush && (way_idx == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_FULL;
      way_idx <= FIRST_IDX;
      abort_q <= 1'b0;
    end else begin
      case (state)
        SEQ_FULL: begin
          if (dwell_hit) begin
            state   <= SEQ_FLUSH;
            way_idx <= FIRST_IDX;
            abort_q <= 1'b0;
          end
        end
        SEQ_FLUSH: begin
          if (flush_done) begin
            if (abort_now) begin
              state <= SEQ_WAKE;
            end else if (way_idx == LAST_IDX) begin
              state <= SEQ_SHRUNK;
            end else begin
              way_idx <= way_idx + 1'b1;
            end
          end else if (high_now) begin
            abort_q <= 1'b1;
          end
        end
        SEQ_SHRUNK: begin
          if (dwell_hit) state <= SEQ_WAKE;
        end
        default: state <= SEQ_FULL;
      endcase
    end
  end

  // R3
  flush_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flush_req));

  // R3
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flush && !flush_done) |=> (flush_req == $past(flush_req)));

  // R7
  abort_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flush && flush_done && abort_now) |=> (flush_req == '0));

endmodule

// File: rtl/wsc_sleep_bank.sv
module wsc_sleep_bank #(
  parameter int NUM_WAYS  = 16,
  parameter int KEEP_WAYS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sleep_set,
  input  logic [$clog2(NUM_WAYS)-1:0]   sleep_idx,
  input  logic                          wake_all,
  output logic [NUM_WAYS-1:0]           way_sleep,
  output logic [$clog2(NUM_WAYS+1)-1:0] awake_count
);

  localparam int IDX_W = $clog2(NUM_WAYS);
  localparam int CNT_W = $clog2(NUM_WAYS + 1);

  function automatic logic [CNT_W-1:0] count_awake(logic [NUM_WAYS-1:0] slp);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int k = 0; k < NUM_WAYS; k++) begin
      if (!slp[k]) n = n + 1'b1;
    end
    return n;
  endfunction

  for (genvar i = 0; i < NUM_WAYS; i++) begin : g_way
    if (i < KEEP_WAYS) begin : g_kept
      assign way_sleep[i] = 1'b0;
    end else begin : g_gated
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          way_sleep[i] <= 1'b0;
        end else if (wake_all) begin
          way_sleep[i] <= 1'b0;
        end else if (sleep_set && (sleep_idx == IDX_W'(i))) begin
          way_sleep[i] <= 1'b1;
        end
      end
    end
  end

  assign awake_count = count_awake(way_sleep);

  // R4
  keep_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    way_sleep[KEEP_WAYS-1:0] == '0);

  // R6
  wake_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_all |=> (way_sleep == '0));

endmodule

// File: rtl/way_shrink_ctrl.sv
module way_shrink_ctrl
  import wsc_pkg::*;
#(
  parameter int NUM_WAYS  = 16,
  parameter int KEEP_WAYS = 2,
  parameter int ACT_W     = 12,
  parameter int MIN_DWELL = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          act_valid,
  input  logic [ACT_W-1:0]              act_sample,
  input  logic [ACT_W-1:0]              lo_thresh,
  input  logic [ACT_W-1:0]              hi_thresh,
  input  logic                          flush_done,
  output logic [NUM_WAYS-1:0]           flush_req,
  output logic [NUM_WAYS-1:0]           way_sleep,
  output logic [$clog2(NUM_WAYS+1)-1:0] active_ways,
  output logic [1:0]                    size_status,
  output logic                          vmin_permit
);

  localparam int IDX_W = $clog2(NUM_WAYS);
  localparam int CNT_W = $clog2(NUM_WAYS + 1);

  logic             dwell_hit;
  logic             high_now;
  logic             filt_clr;
  logic             look_high;
  logic             sleep_set;
  logic [IDX_W-1:0] sleep_idx;
  logic             wake_all;
  seq_state_e       state;

  wsc_dwell_filter #(.ACT_W(ACT_W), .MIN_DWELL(MIN_DWELL)) u_filter (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (filt_clr),
    .look_high  (look_high),
    .act_valid  (act_valid),
    .act_sample (act_sample),
    .lo_thresh  (lo_thresh),
    .hi_thresh  (hi_thresh),
    .dwell_hit  (dwell_hit),
    .high_now   (high_now)
  );

  wsc_way_sequencer #(.NUM_WAYS(NUM_WAYS), .KEEP_WAYS(KEEP_WAYS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .dwell_hit  (dwell_hit),
    .high_now   (high_now),
    .flush_done (flush_done),
    .flush_req  (flush_req),
    .sleep_set  (sleep_set),
    .sleep_idx  (sleep_idx),
    .wake_all   (wake_all),
    .filt_clr   (filt_clr),
    .look_high  (look_high),
    .state      (state)
  );

  wsc_sleep_bank #(.NUM_WAYS(NUM_WAYS), .KEEP_WAYS(KEEP_WAYS)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_set   (sleep_set),
    .sleep_idx   (sleep_idx),
    .wake_all    (wake_all),
    .way_sleep   (way_sleep),
    .awake_count (active_ways)
  );

  assign size_status = size_of(state);
  assign vmin_permit = (state == SEQ_SHRUNK);

  // R3
  no_flush_sleeping_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req & way_sleep) == '0);

  // R5
  permit_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vmin_permit |-> (active_ways == CNT_W'(KEEP_WAYS)));

  // R8
  permit_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vmin_permit |-> (size_status == 2'b01));

  for (genvar i = 0; i < NUM_WAYS; i++) begin : g_chk
    // R4
    sleep_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(way_sleep[i]) |-> $past(flush_req[i] && flush_done));
  end

endmodule

// File: tb/way_shrink_ctrl_test.sv
`timescale 1ns/1ps
module way_shrink_ctrl_test;

  localparam int N  = 16;
  localparam int K  = 2;
  localparam int AW = 12;
  localparam int D  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          act_valid = 1'b0;
  logic [AW-1:0] act_sample = '0;
  logic [AW-1:0] lo_thresh = 12'd100;
  logic [AW-1:0] hi_thresh = 12'd300;
  logic          flush_done = 1'b0;
  logic [N-1:0]  flush_req;
  logic [N-1:0]  way_sleep;
  logic [4:0]    active_ways;
  logic [1:0]    size_status;
  logic          vmin_permit;

  int vectors = 0;
  int errors  = 0;

  always #2 clk = ~clk;

  way_shrink_ctrl #(.NUM_WAYS(N), .KEEP_WAYS(K), .ACT_W(AW), .MIN_DWELL(D)) uut (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_sample(act_sample),
    .lo_thresh(lo_thresh), .hi_thresh(hi_thresh), .flush_done(flush_done),
    .flush_req(flush_req), .way_sleep(way_sleep), .active_ways(active_ways),
    .size_status(size_status), .vmin_permit(vmin_permit)
  );

  // Independent cycle model: 0 full, 1 flushing, 2 shrunk, 3 waking
  int           m_st;
  int           m_cnt;
  int           m_idx;
  logic         m_abort;
  logic [N-1:0] m_sleep;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_idx = K; m_abort = 1'b0; m_sleep = '0;
    end else begin
      logic hi_s;
      hi_s = act_valid && (act_sample > hi_thresh);
      case (m_st)
        0: if (act_valid) begin
             if (act_sample < lo_thresh) begin
               if (m_cnt == D - 1) begin
                 m_st = 1; m_cnt = 0; m_idx = K; m_abort = 1'b0;
               end else m_cnt++;
             end else m_cnt = 0;
           end
        1: if (flush_done) begin
             if (m_abort || hi_s) begin m_sleep = '0; m_st = 3; end
             else begin
               m_sleep[m_idx] = 1'b1;
               if (m_idx == N - 1) begin m_st = 2; m_cnt = 0; end
               else m_idx++;
             end
           end else if (hi_s) m_abort = 1'b1;
        2: if (act_valid) begin
             if (hi_s) begin
               if (m_cnt == D - 1) begin m_sleep = '0; m_st = 3; m_cnt = 0; end
               else m_cnt++;
             end else m_cnt = 0;
           end
        default: begin m_st = 0; m_cnt = 0; end
      endcase
    end
  end

  function automatic int awake_of(logic [N-1:0] s);
    int n = N;
    for (int k = 0; k < N; k++) if (s[k]) n--;
    return n;
  endfunction

  function automatic logic [1:0] status_of(int st);
    return (st == 0) ? 2'b00 : (st == 2) ? 2'b01 : 2'b10;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_check();
    logic [N-1:0] exp_req;
    exp_req = (m_st == 1) ? (N'(1) << m_idx) : '0;
    check("R3 flush_req", 32'(flush_req), 32'(exp_req));
    check("R4 way_sleep", 32'(way_sleep), 32'(m_sleep));
    check("R8 size_status", 32'(size_status), 32'(status_of(m_st)));
    check("R5 vmin_permit", 32'(vmin_permit), 32'(m_st == 2));
    check("R10 active_ways", 32'(active_ways), 32'(awake_of(m_sleep)));
  endtask

  task automatic cyc(logic v, logic [AW-1:0] s, logic d);
    act_valid = v; act_sample = s; flush_done = d;
    @(negedge clk);
    model_check();
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2468));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 sleep", 32'(way_sleep), 0);
    check("R1 req", 32'(flush_req), 0);
    check("R1 active", 32'(active_ways), 16);
    check("R1 status", 32'(size_status), 0);
    check("R1 permit", 32'(vmin_permit), 0);

    // R9: an in-between sample resets the low run; R2: invalid cycles do not
    repeat (3) cyc(1, 12'd50, 0);
    cyc(1, 12'd100, 0);
    repeat (3) cyc(1, 12'd20, 0);
    cyc(0, 12'd999, 0);
    check("R9 run reset by mid sample", 32'(size_status), 0);
    cyc(1, 12'd20, 0);
    check("R2 shrink started", 32'(size_status), 2);
    check("R2 first request", 32'(flush_req), 32'h4);

    // R3/R4 ordered flush with handshake
    for (int w = K; w < N; w++) begin
      cyc(0, 0, 0);
      check("R3 request held", 32'(flush_req), 32'(1) << w);
      cyc(0, 0, 1);
      check("R4 sleep after done", 32'(way_sleep[w]), 1);
    end
    check("R5 status shrunk", 32'(size_status), 1);
    check("R5 active two", 32'(active_ways), 2);
    check("R5 permit", 32'(vmin_permit), 1);
    cyc(0, 0, 1);
    check("R9 stray done ignored", 32'(way_sleep), 32'hFFFC);

    // R6 expand
    repeat (3) cyc(1, 12'd400, 0);
    cyc(1, 12'd300, 0);
    repeat (3) cyc(1, 12'd400, 0);
    check("R9 run reset in shrunk", 32'(size_status), 1);
    cyc(1, 12'd400, 0);
    check("R6 all awake", 32'(way_sleep), 0);
    check("R6 moving", 32'(size_status), 2);
    cyc(0, 0, 0);
    check("R6 full again", 32'(size_status), 0);

    // R7 abort during shrink
    repeat (4) cyc(1, 12'd10, 0);
    cyc(0, 0, 1);
    cyc(1, 12'd500, 0);
    cyc(0, 0, 1);
    check("R7 aborted sleep", 32'(way_sleep), 0);
    check("R7 no request", 32'(flush_req), 0);
    check("R7 moving", 32'(size_status), 2);
    cyc(0, 0, 0);
    check("R7 full", 32'(size_status), 0);

    // Random phase checked against the model
    for (int blk = 0; blk < 40; blk++) begin
      int bias;
      bias = int'($urandom_range(0, 2));
      for (int c = 0; c < 150; c++) begin
        logic v, d;
        logic [AW-1:0] s;
        v = ($urandom_range(0, 3) != 0);
        case (bias)
          0: s = AW'($urandom_range(0, 140));
          1: s = AW'($urandom_range(60, 340));
          default: s = AW'($urandom_range(260, 600));
        endcase
        d = (flush_req != '0) ? ($urandom_range(0, 2) == 0)
                              : ($urandom_range(0, 19) == 0);
        cyc(v, s, d);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule